// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector load or store into a stream of per-element memory requests. A single start handshake captures the whole operation: a base address, an element count, a signed stride, a flag that selects indexed addressing, a flag for stores, a mask enable with one mask bit per element, and a flat vector of per-element offsets. After the handshake the block walks the elements in ascending order, one element per cycle. For each element that is not masked off it presents a request with the word address, the element number and a write flag, under a valid/ready handshake.

In strided mode, each address is the base plus the element number times the stride. In indexed mode, which serves gather and scatter, each address is the base plus that element's offset. Masked-off elements use up their cycle and produce no request. When the last element has retired, the block raises a one-cycle completion pulse and reports how many requests were accepted. A long array is handled by strip-mining: the caller issues a series of operations, each with its own length. An example is eight passes of 64 elements followed by one pass of 15.

Top module: `vmem_addr_gen`

## Requirements
- R1: After reset, `opReady` is 1, `reqValid` is 0, `opDone` is 0 and `reqCount` is 0.
- R2: In strided mode (`opIndexed`=0), element i requests address `opBase + i*opStride`, taken modulo 2^32, with `opStride` read as signed two's complement. Elements appear in ascending order of `reqElem`.
- R3: In indexed mode (`opIndexed`=1), element i requests address `opBase + opOffsets[32*i+31:32*i]`, taken modulo 2^32.
- R4: With `opMaskEn`=1, element i produces a request only when `opMask[i]` is 1. With `opMaskEn`=0, every element up to the length produces a request, whatever `opMask` holds.
- R5: `reqWrite` equals the `opStore` value captured at the start handshake, for every request of that operation.
- R6: While `reqValid` is 1 and `reqReady` is 0, `reqValid`, `reqAddr`, `reqElem` and `reqWrite` keep their values on the next cycle.
- R7: `opDone` is high for exactly one cycle, in the cycle after the last element retires. At that point `reqCount` equals the number of accepted requests, and it holds that value until the next start.
- R8: A length of 0 raises `opDone` in the cycle after the start handshake and produces no request.
- R9: All operation inputs are sampled only at the start handshake (`opValid` and `opReady` both 1). Changes to them during an operation have no effect. `opReady` is 0 from the handshake until the cycle after `opDone`.
- R10: The length can be reloaded on every operation. Back-to-back operations with different lengths each walk exactly their own length.
- R11: A requested length above 64 is treated as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | Start request for a new operation |
| opReady | output | 1 | Block is idle and accepts a start |
| opBase | input | 32 | Base word address |
| opLen | input | 7 | Element count (0 to 64; larger values clamp to 64) |
| opStride | input | 32 | Signed stride in words |
| opIndexed | input | 1 | 1 selects base plus per-element offset |
| opStore | input | 1 | 1 marks the operation as a store |
| opMaskEn | input | 1 | 1 enables per-element masking |
| opMask | input | 64 | Mask bit i enables element i |
| opOffsets | input | 2048 | Element i offset at bits 32*i+31 to 32*i |
| reqValid | output | 1 | Element request valid |
| reqReady | input | 1 | Memory side accepts the request |
| reqAddr | output | 32 | Word address of the element |
| reqElem | output | 6 | Element number |
| reqWrite | output | 1 | Request is a write |
| opDone | output | 1 | One-cycle completion pulse |
| reqCount | output | 7 | Accepted requests in the current or last operation |

## Verification
A wrong stride accumulator or a wrong offset selection shows up on the very first affected request, as a wrong `reqAddr` next to the correct `reqElem`. A broken element counter shows up either as a repeated or skipped `reqElem` or as an `opDone` that comes early or late against the number of accepted requests. A fault in mask handling shows up as a request for a disabled element, or a missing one for an enabled element, within that element's cycle. A fault in stall handling shows up one cycle after a refused request, when the request fields change.

// File: rtl/vmag_pkg.sv
package vmag_pkg;

  typedef enum logic [1:0] {
    StIdle = 2'd0,
    StRun  = 2'd1,
    StDone = 2'd2
  } seqState_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic loadOp;    // capture operation operands
    logic stepElem;  // current element retires this cycle
  } seqStrobe_t;

endpackage

// File: rtl/vmag_ctrl.sv
module vmag_ctrl
  import vmag_pkg::*;
#(
  parameter int NumElem = 64,
  localparam int ElemW = $clog2(NumElem),
  localparam int LenW  = ElemW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  output logic             opReady,
  input  logic [LenW-1:0]  opLen,
  input  logic             elemActive,
  input  logic             reqReady,
  output logic             reqValid,
  output logic [ElemW-1:0] curElem,
  output logic             opDone,
  output logic [LenW-1:0]  reqCount,
  output seqStrobe_t       strobe
);

  localparam logic [LenW-1:0] MaxLen = LenW'(NumElem);

  seqState_e       state;
  logic [LenW-1:0] lenReg;
  logic [LenW-1:0] effLen;
  logic            startFire;
  logic            lastElem;

  assign effLen    = (opLen > MaxLen) ? MaxLen : opLen;
  assign opReady   = (state == StIdle);
  assign startFire = opReady && opValid;
  assign lastElem  = ({1'b0, curElem} == (lenReg - LenW'(1)));
  assign reqValid  = (state == StRun) && elemActive;
  assign opDone    = (state == StDone);

  always_comb begin
    strobe          = '0;
    strobe.loadOp   = startFire;
    strobe.stepElem = (state == StRun) && (!elemActive || reqReady);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= StIdle;
      lenReg   <= '0;
      curElem  <= '0;
      reqCount <= '0;
    end else begin
      case (state)
        StIdle: begin
          if (startFire) begin
            lenReg   <= effLen;
            curElem  <= '0;
            reqCount <= '0;
            state    <= (effLen == '0) ? StDone : StRun;
          end
        end
        StRun: begin
          if (reqValid && reqReady) reqCount <= reqCount + LenW'(1);
          if (strobe.stepElem) begin
            if (lastElem) state <= StDone;
            else          curElem <= curElem + ElemW'(1);
          end
        end
        default: state <= StIdle;
      endcase
    end
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> !opDone);

  a_r2_elem_in_range: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ({1'b0, curElem} < lenReg));

  a_r8_zero_len_done: assert property (@(posedge clk) disable iff (!rstN)
    (startFire && opLen == '0) |=> opDone);

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    opDone |-> (reqCount <= lenReg));

endmodule

// File: rtl/vmag_dpath.sv
module vmag_dpath
  import vmag_pkg::*;
#(
  parameter int NumElem = 64,
  parameter int AddrW   = 32,
  localparam int ElemW  = $clog2(NumElem)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobe_t               strobe,
  input  logic [AddrW-1:0]         opBase,
  input  logic [AddrW-1:0]         opStride,
  input  logic                     opIndexed,
  input  logic                     opStore,
  input  logic                     opMaskEn,
  input  logic [NumElem-1:0]       opMask,
  input  logic [NumElem*AddrW-1:0] opOffsets,
  input  logic [ElemW-1:0]         curElem,
  output logic                     elemActive,
  output logic [AddrW-1:0]         reqAddr,
  output logic                     reqWrite
);

  logic [AddrW-1:0]   baseReg;
  logic [AddrW-1:0]   strideReg;
  logic [AddrW-1:0]   strideAcc;
  logic               idxMode;
  logic               storeReg;
  logic               maskOn;
  logic [NumElem-1:0] maskReg;
  logic [AddrW-1:0]   offsetReg [NumElem];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg   <= '0;
      strideReg <= '0;
      strideAcc <= '0;
      idxMode   <= 1'b0;
      storeReg  <= 1'b0;
      maskOn    <= 1'b0;
      maskReg   <= '0;
    end else if (strobe.loadOp) begin
      baseReg   <= opBase;
      strideReg <= opStride;
      strideAcc <= opBase;
      idxMode   <= opIndexed;
      storeReg  <= opStore;
      maskOn    <= opMaskEn;
      maskReg   <= opMask;
    end else if (strobe.stepElem) begin
      strideAcc <= strideAcc + strideReg;
    end
  end

  for (genvar g = 0; g < NumElem; g++) begin : gOffset
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              offsetReg[g] <= '0;
      else if (strobe.loadOp) offsetReg[g] <= opOffsets[g*AddrW +: AddrW];
    end
  end

  assign elemActive = !maskOn || maskReg[curElem];
  assign reqAddr    = idxMode ? (baseReg + offsetReg[curElem]) : strideAcc;
  assign reqWrite   = storeReg;

endmodule

// File: rtl/vmem_addr_gen.sv
module vmem_addr_gen
  import vmag_pkg::*;
#(
  parameter int NumElem = 64,
  parameter int AddrW   = 32,
  localparam int ElemW  = $clog2(NumElem),
  localparam int LenW   = ElemW + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     opValid,
  output logic                     opReady,
  input  logic [AddrW-1:0]         opBase,
  input  logic [LenW-1:0]          opLen,
  input  logic [AddrW-1:0]         opStride,
  input  logic                     opIndexed,
  input  logic                     opStore,
  input  logic                     opMaskEn,
  input  logic [NumElem-1:0]       opMask,
  input  logic [NumElem*AddrW-1:0] opOffsets,
  output logic                     reqValid,
  input  logic                     reqReady,
  output logic [AddrW-1:0]         reqAddr,
  output logic [ElemW-1:0]         reqElem,
  output logic                     reqWrite,
  output logic                     opDone,
  output logic [LenW-1:0]          reqCount
);

  seqStrobe_t strobe;
  logic       elemActive;

  vmag_ctrl #(.NumElem(NumElem)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .opReady   (opReady),
    .opLen     (opLen),
    .elemActive(elemActive),
    .reqReady  (reqReady),
    .reqValid  (reqValid),
    .curElem   (reqElem),
    .opDone    (opDone),
    .reqCount  (reqCount),
    .strobe    (strobe)
  );

  vmag_dpath #(.NumElem(NumElem), .AddrW(AddrW)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .opBase    (opBase),
    .opStride  (opStride),
    .opIndexed (opIndexed),
    .opStore   (opStore),
    .opMaskEn  (opMaskEn),
    .opMask    (opMask),
    .opOffsets (opOffsets),
    .curElem   (reqElem),
    .elemActive(elemActive),
    .reqAddr   (reqAddr),
    .reqWrite  (reqWrite)
  );

  a_r6_hold_stall: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqAddr)
                                 && $stable(reqElem) && $stable(reqWrite)));

  a_r9_busy_no_start: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !opReady);

endmodule

// File: tb/vmem_addr_gen_tb.sv
module vmem_addr_gen_tb;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          opValid = 1'b0;
  logic          opReady;
  logic [31:0]   opBase = '0;
  logic [6:0]    opLen = '0;
  logic [31:0]   opStride = '0;
  logic          opIndexed = 1'b0;
  logic          opStore = 1'b0;
  logic          opMaskEn = 1'b0;
  logic [63:0]   opMask = '0;
  logic [2047:0] opOffsets = '0;
  logic          reqValid;
  logic          reqReady = 1'b0;
  logic [31:0]   reqAddr;
  logic [5:0]    reqElem;
  logic          reqWrite;
  logic          opDone;
  logic [6:0]    reqCount;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // captured operation
  logic [31:0]   cBase, cStride;
  logic [6:0]    cLen;
  logic          cIndexed, cStore, cMaskEn;
  logic [63:0]   cMask;
  logic [2047:0] cOffsets;

  always #4 clk = ~clk;

  vmem_addr_gen u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opReady(opReady),
    .opBase(opBase), .opLen(opLen), .opStride(opStride),
    .opIndexed(opIndexed), .opStore(opStore), .opMaskEn(opMaskEn),
    .opMask(opMask), .opOffsets(opOffsets), .reqValid(reqValid),
    .reqReady(reqReady), .reqAddr(reqAddr), .reqElem(reqElem),
    .reqWrite(reqWrite), .opDone(opDone), .reqCount(reqCount)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act=%0d expected<=%0d cycles", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expAddr(input int i);
    if (cIndexed) return cBase + cOffsets[32*i +: 32];
    return cBase + 32'(i) * cStride;
  endfunction

  task automatic runOp(input string req, input int rdyPct);
    int expElem[64];
    int nExp = 0;
    int effLen;
    int k = 0;
    bit prevHold = 0;
    bit seenDone = 0;
    logic [31:0] pAddr;
    logic [5:0]  pElem;
    logic        pWrite;
    effLen = (cLen > 7'd64) ? 64 : int'(cLen);
    for (int i = 0; i < effLen; i++)
      if (!cMaskEn || cMask[i]) begin expElem[nExp] = i; nExp++; end
    @(negedge clk);
    opValid = 1'b1; opBase = cBase; opLen = cLen; opStride = cStride;
    opIndexed = cIndexed; opStore = cStore; opMaskEn = cMaskEn;
    opMask = cMask; opOffsets = cOffsets;
    @(negedge clk);
    // R9: scramble inputs after the handshake
    opValid = 1'b0; opBase = $urandom; opStride = $urandom; opLen = 7'($urandom);
    opIndexed = ~cIndexed; opStore = ~cStore; opMaskEn = ~cMaskEn;
    opMask = {$urandom, $urandom};
    for (int c = 0; c < 1000; c++) begin
      reqReady = (($urandom % 100) < rdyPct);
      #1;
      if (opDone) begin
        check(k == nExp, req, "R7 accepted before done", 64'(k), 64'(nExp));
        check(reqCount == 7'(nExp), req, "R7 reqCount", 64'(reqCount), 64'(nExp));
        check(!reqValid, req, "R7 no req at done", 64'(reqValid), 64'd0);
        seenDone = 1;
        break;
      end
      if (prevHold) begin
        check(reqValid && reqAddr == pAddr && reqElem == pElem && reqWrite == pWrite,
              req, "R6 hold under stall", 64'(reqAddr), 64'(pAddr));
      end
      if (reqValid) begin
        check(!opReady, req, "R9 busy", 64'(opReady), 64'd0);
        if (k < nExp) begin
          check(reqElem == 6'(expElem[k]), req, "R2/R4 element", 64'(reqElem), 64'(expElem[k]));
          check(reqAddr == expAddr(expElem[k]), req, "R2/R3 address", 64'(reqAddr),
                64'(expAddr(expElem[k])));
          check(reqWrite == cStore, req, "R5 write flag", 64'(reqWrite), 64'(cStore));
        end else begin
          check(1'b0, req, "R4 extra request", 64'(k), 64'(nExp));
        end
      end
      prevHold = reqValid && !reqReady;
      pAddr = reqAddr; pElem = reqElem; pWrite = reqWrite;
      if (reqValid && reqReady) k++;
      @(negedge clk);
    end
    check(seenDone, req, "R7 done seen", 64'(seenDone), 64'd1);
    @(negedge clk);
    #1;
    check(!opDone && opReady, req, "R7 single pulse / ready", 64'({opDone, opReady}), 64'b01);
    check(reqCount == 7'(nExp), req, "R7 count held", 64'(reqCount), 64'(nExp));
  endtask

  task automatic setCfg(input logic [31:0] b, input logic [6:0] l, input logic [31:0] s,
                        input logic ix, input logic st, input logic me, input logic [63:0] m);
    cBase = b; cLen = l; cStride = s; cIndexed = ix; cStore = st; cMaskEn = me; cMask = m;
    for (int i = 0; i < 64; i++) cOffsets[32*i +: 32] = $urandom;
  endtask

  initial begin
    void'($urandom(32'd1234));
    cOffsets = '0;
    #1;
    check(opReady && !reqValid && !opDone && reqCount == 0, "R1", "reset state",
          64'({opReady, reqValid, opDone}), 64'b100);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(opReady && !reqValid && !opDone && reqCount == 0, "R1", "after reset release",
          64'({opReady, reqValid, opDone}), 64'b100);

    setCfg(32'h1000, 7'd8, 32'd1, 0, 0, 0, '0);           runOp("R2 unit stride", 100);
    setCfg(32'h2000, 7'd5, 32'hFFFF_FFFD, 0, 1, 0, '0);   runOp("R2 negative stride", 60);
    setCfg(32'hFFFF_FFF0, 7'd64, 32'd3, 0, 1, 0, '0);     runOp("R2 wrap full len", 50);
    setCfg(32'h3000, 7'd0, 32'd4, 0, 1, 0, '1);           runOp("R8 zero length", 100);
    setCfg(32'h4000, 7'd20, 32'd0, 1, 0, 0, '0);          runOp("R3 gather", 70);
    setCfg(32'h5000, 7'd20, 32'd0, 1, 1, 0, '0);          runOp("R3 scatter", 40);
    setCfg(32'h6000, 7'd64, 32'd2, 0, 1, 1, {$urandom, $urandom}); runOp("R4 masked store", 60);
    setCfg(32'h6800, 7'd30, 32'd1, 1, 0, 1, 64'h0);       runOp("R4 all masked", 100);
    setCfg(32'h7000, 7'd10, 32'd1, 0, 0, 0, 64'h0);       runOp("R4 mask disabled", 100);
    setCfg(32'h7800, 7'd100, 32'd1, 0, 0, 0, '0);         runOp("R11 clamp length", 90);
    // R10: strip-mining 527 elements as 8x64 then 15
    for (int p = 0; p < 9; p++) begin
      setCfg(32'h10000 + 32'(p * 64), (p < 8) ? 7'd64 : 7'd15, 32'd1, 0, 0, 0, '0);
      runOp("R10 strip pass", 80);
    end
    for (int r = 0; r < 25; r++) begin
      setCfg($urandom, 7'($urandom % 66), $urandom % 16 - 8, 1'($urandom), 1'($urandom),
             1'($urandom), {$urandom, $urandom});
      runOp("R2/R3/R4 random", 20 + int'($urandom % 80));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule